// File: doc/BRIEF.md
# Transmit Auto-Poll Interval Timer

This block produces the poll pulses that wake a network controller's transmit engine while it sits suspended. Without it, the host must write a poll register each time it queues new descriptors. A 2-bit interval field either turns automatic polling off or picks one of three periods: 200 us, 800 us or 1.6 ms. Each period is converted to a clock-cycle count at elaboration from a clock-frequency parameter.

The timer runs only while the transmit-suspended status input is high. It is held at zero at all other times. It starts again from zero when suspension begins, when the interval field changes, or when the host writes a poll. A host poll write gives a pulse on the next cycle whatever the interval field or the suspended state. The output is a registered single-cycle strobe for each poll.

Top module: `tx_autopoll_timer`

## Requirements
- R1: While reset is asserted, poll_o is 0 and the timer is cleared. After reset, the first automatic poll comes exactly N cycles after the first clock edge that samples tx_susp_i high, where N is the selected interval count.
- R2: With int_sel_i = 2'b00, no automatic poll is ever produced. Only host writes pulse poll_o.
- R3: With int_sel_i = 2'b01 and the transmit process suspended, poll_o pulses every N1 = CLK_HZ*200/1000000 cycles (200 us).
- R4: With int_sel_i = 2'b10 and the transmit process suspended, poll_o pulses every N2 = CLK_HZ*800/1000000 cycles (800 us).
- R5: With int_sel_i = 2'b11 and the transmit process suspended, poll_o pulses every N3 = CLK_HZ*1600/1000000 cycles (1.6 ms).
- R6: While tx_susp_i is low, no automatic poll is produced, whatever the interval setting.
- R7: When tx_susp_i rises, the interval restarts. The first pulse comes N cycles after the edge that first samples it high.
- R8: A change of int_sel_i while suspended restarts the interval. The next pulse comes N(new) cycles after the edge that samples the new value.
- R9: A host poll write (poll_wr_i high at an edge) makes poll_o high after that edge, for any setting and state. It also restarts the interval, so the next automatic pulse comes N cycles later.
- R10: A partly elapsed interval is discarded when suspension ends. On re-entry, a full N cycles pass before the next pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (also used as the software reset) |
| int_sel_i | input | 2 | Interval select: 00 off, 01 200 us, 10 800 us, 11 1.6 ms |
| tx_susp_i | input | 1 | High while the transmit process is suspended |
| poll_wr_i | input | 1 | Host poll-register write strobe |
| poll_o | output | 1 | Single-cycle transmit poll pulse |

## Verification
On every cycle the assertions check three things. A host write is followed by a pulse. No pulse can appear unless the previous cycle had a host write or an active suspended state with a non-zero interval. The counter either advances by one or returns to zero, and it always returns to zero after a clear. The exact interval lengths and the restart points can only be shown by the bench's scenarios. These cover suspension entry, interval-field changes, host writes mid-interval, a re-entry after a partial count, and a reset in the middle of a count, each measured in cycles against counts the bench computes from the clock parameter.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;

   typedef enum logic [1:0] {
      TAP_OFF   = 2'b00,
      TAP_SHORT = 2'b01,
      TAP_MID   = 2'b10,
      TAP_LONG  = 2'b11
   } tap_sel_e;

   // Number of clock cycles in a period given in microseconds.
   function automatic longint unsigned us_to_cycles(input longint unsigned clk_hz,
                                                    input longint unsigned us);
      return (clk_hz * us) / 64'd1000000;
   endfunction

endpackage

// File: rtl/tap_interval_decode.sv
`timescale 1ns/1ps
module tap_interval_decode #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned LIM1  = 6600,
   parameter int unsigned LIM2  = 26400,
   parameter int unsigned LIM3  = 52800
) (
   input  logic [1:0]       sel_i,
   output logic             en_o,
   output logic [CNT_W-1:0] term_o
);
   import tap_pkg::*;

   localparam int unsigned NSEL = 4;
   localparam int unsigned LIMS [NSEL] = '{0, LIM1, LIM2, LIM3};

   logic [CNT_W-1:0] tbl [NSEL];

   // One terminal count per encoding; the off code carries zero.
   for (genvar g = 0; g < NSEL; g++) begin : g_tbl
      assign tbl[g] = CNT_W'(LIMS[g]);
   end

   assign en_o   = (tap_sel_e'(sel_i) != TAP_OFF);
   assign term_o = tbl[sel_i];

endmodule

// File: rtl/tap_restart_gen.sv
`timescale 1ns/1ps
module tap_restart_gen (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] sel_i,
   input  logic       susp_i,
   input  logic       host_wr_i,
   output logic       restart_o
);
   logic       susp_q;
   logic [1:0] sel_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         susp_q <= 1'b0;
         sel_q  <= 2'b00;
      end else begin
         susp_q <= susp_i;
         sel_q  <= sel_i;
      end
   end

   // Start a fresh interval on suspension entry (R7), field change (R8) or host write (R9).
   assign restart_o = (susp_i & ~susp_q) | (sel_i != sel_q) | host_wr_i;

endmodule

// File: rtl/tap_interval_counter.sv
`timescale 1ns/1ps
module tap_interval_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic [CNT_W-1:0] term_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             fire_o
);
   logic [CNT_W-1:0] cnt_q;

   assign fire_o = ~clear_i & (cnt_q == term_i - CNT_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (clear_i) cnt_q <= '0;
      else if (fire_o)  cnt_q <= '0;
      else              cnt_q <= cnt_q + CNT_W'(1);
   end

   assign cnt_o = cnt_q;

   // R10: a clear always leaves the counter at zero on the next cycle
   a_r10_clear_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (cnt_o == '0));

   // R3: a nonzero count only ever comes from one step up
   a_r3_count_step : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_o != '0) |-> (cnt_o == $past(cnt_o) + CNT_W'(1)));

endmodule

// File: rtl/tx_autopoll_timer.sv
`timescale 1ns/1ps
module tx_autopoll_timer #(
   parameter int unsigned CLK_HZ  = 33_000_000,
   parameter int unsigned INT1_US = 200,
   parameter int unsigned INT2_US = 800,
   parameter int unsigned INT3_US = 1600
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] int_sel_i,
   input  logic       tx_susp_i,
   input  logic       poll_wr_i,
   output logic       poll_o
);
   import tap_pkg::*;

   localparam int unsigned N1    = int'(us_to_cycles(CLK_HZ, INT1_US));
   localparam int unsigned N2    = int'(us_to_cycles(CLK_HZ, INT2_US));
   localparam int unsigned N3    = int'(us_to_cycles(CLK_HZ, INT3_US));
   localparam int unsigned NMAX  = (N1 > N2) ? ((N1 > N3) ? N1 : N3) : ((N2 > N3) ? N2 : N3);
   localparam int unsigned CNT_W = $clog2(NMAX + 1);

   if (N1 < 2 || N2 < 2 || N3 < 2) begin : g_chk_short
      $error("tx_autopoll_timer: every interval must last at least two cycles");
   end
   if (CLK_HZ < 1_000_000) begin : g_chk_clk
      $info("tx_autopoll_timer: slow clock, intervals are coarse");
   end

   logic             en;
   logic             restart;
   logic             clear;
   logic             fire;
   logic             poll_q;
   logic [CNT_W-1:0] term;
   logic [CNT_W-1:0] cnt;

   tap_interval_decode #(
      .CNT_W (CNT_W),
      .LIM1  (N1),
      .LIM2  (N2),
      .LIM3  (N3)
   ) u_decode (
      .sel_i  (int_sel_i),
      .en_o   (en),
      .term_o (term)
   );

   tap_restart_gen u_restart (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sel_i     (int_sel_i),
      .susp_i    (tx_susp_i),
      .host_wr_i (poll_wr_i),
      .restart_o (restart)
   );

   // Hold at zero while idle or disabled (R6, R10); restart on events.
   assign clear = restart | ~tx_susp_i | ~en;

   tap_interval_counter #(
      .CNT_W (CNT_W)
   ) u_counter (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear),
      .term_i  (term),
      .cnt_o   (cnt),
      .fire_o  (fire)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) poll_q <= 1'b0;
      else         poll_q <= poll_wr_i | fire;
   end

   assign poll_o = poll_q;

   // R9: host write always yields a pulse next cycle
   a_r9_host_poll : assert property (@(posedge clk_i) disable iff (!rst_ni)
      poll_wr_i |=> poll_o);

   // R6: no pulse without suspension unless the host wrote
   a_r6_idle_quiet : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tx_susp_i && !poll_wr_i) |=> !poll_o);

   // R2: off setting never polls by itself
   a_r2_off_quiet : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int_sel_i == 2'b00 && !poll_wr_i) |=> !poll_o);

   // R1: during reset nothing is emitted
   always_comb begin
      if (!rst_ni) a_r1_reset_quiet : assert (poll_o == 1'b0);
   end

endmodule

// File: tb/tb_tx_autopoll_timer.sv
`timescale 1ns/1ps
module tb_tx_autopoll_timer;

   localparam int unsigned CLK_HZ = 100_000;
   localparam int N1 = CLK_HZ * 200 / 1_000_000;
   localparam int N2 = CLK_HZ * 800 / 1_000_000;
   localparam int N3 = CLK_HZ * 1600 / 1_000_000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] sel = 2'b00;
   logic       susp = 1'b0;
   logic       wr = 1'b0;
   logic       poll;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tx_autopoll_timer #(.CLK_HZ(CLK_HZ)) dut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .int_sel_i (sel),
      .tx_susp_i (susp),
      .poll_wr_i (wr),
      .poll_o    (poll)
   );

   function automatic int lim(input logic [1:0] s);
      case (s)
         2'b01:   return N1;
         2'b10:   return N2;
         2'b11:   return N3;
         default: return 0;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Negedges until poll is seen high (first wait covers the next rising edge).
   task automatic wait_pulse(input int limit, output int n);
      n = -1;
      for (int i = 1; i <= limit; i++) begin
         @(negedge clk);
         if (poll) begin
            n = i;
            break;
         end
      end
   endtask

   task automatic count_pulses(input int cycles, output int n);
      n = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (poll) n++;
      end
   endtask

   task automatic host_poll(input string req);
      wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
      check(poll == 1'b1, req, int'(poll), 1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 100_000);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      check(poll == 1'b0, "R1 reset output", int'(poll), 0);
      rst_n = 1'b1;

      // R2: off setting while suspended
      sel = 2'b00; susp = 1'b1;
      count_pulses(400, n);
      check(n == 0, "R2 no auto poll when off", n, 0);
      host_poll("R9 host poll when off");
      count_pulses(200, n);
      check(n == 0, "R2 quiet after host poll", n, 0);

      // R3/R4/R5 interval per encoding, R7 entry restart
      for (int s = 1; s < 4; s++) begin
         susp = 1'b0;
         repeat (2) @(negedge clk);
         sel = 2'(s); susp = 1'b1;
         wait_pulse(lim(2'(s)) + 10, n);
         check(n == lim(2'(s)) + 1, "R7 first pulse after entry", n, lim(2'(s)) + 1);
         for (int k = 0; k < 2; k++) begin
            wait_pulse(lim(2'(s)) + 10, n);
            case (s)
               1: check(n == N1, "R3 period 01", n, N1);
               2: check(n == N2, "R4 period 10", n, N2);
               default: check(n == N3, "R5 period 11", n, N3);
            endcase
         end
      end

      // R6: not suspended
      susp = 1'b0; sel = 2'b01;
      count_pulses(3 * N1, n);
      check(n == 0, "R6 quiet while not suspended", n, 0);
      host_poll("R9 host poll while not suspended");
      count_pulses(2 * N1, n);
      check(n == 0, "R6 quiet after host poll", n, 0);

      // R10: partial interval discarded
      susp = 1'b1;
      count_pulses(N1 - 3, n);
      check(n == 0, "R10 no pulse in partial interval", n, 0);
      susp = 1'b0;
      repeat (5) @(negedge clk);
      susp = 1'b1;
      wait_pulse(N1 + 10, n);
      check(n == N1 + 1, "R10 full interval on re-entry", n, N1 + 1);

      // R8: field change restarts
      susp = 1'b0;
      repeat (2) @(negedge clk);
      sel = 2'b11; susp = 1'b1;
      count_pulses(N3 / 2, n);
      check(n == 0, "R8 no pulse before change", n, 0);
      sel = 2'b01;
      wait_pulse(N1 + 10, n);
      check(n == N1 + 1, "R8 restart on field change", n, N1 + 1);

      // R9: host write mid-interval restarts
      sel = 2'b10;
      wait_pulse(N2 + 10, n);
      check(n == N2 + 1, "R8 restart to 10", n, N2 + 1);
      repeat (30) @(negedge clk);
      host_poll("R9 host poll while suspended");
      wait_pulse(N2 + 10, n);
      check(n == N2, "R9 restart after host poll", n, N2);

      // R1: reset in the middle of a count
      sel = 2'b01;
      repeat (N1 / 2) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(poll == 1'b0, "R1 output cleared in reset", int'(poll), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      wait_pulse(N1 + 10, n);
      check(n == N1 + 1, "R1 first pulse after reset", n, N1 + 1);

      finish_run();
   end

endmodule